// File: doc/BRIEF.md
# Feedback Vector Rotator with Loop Return Subtractor

This block is the correction datapath of a digital Cartesian-feedback transmitter stage. Every clock it accepts one signed baseband sample pair (`in_i`, `in_q`), one signed feedback pair (`fb_i`, `fb_q`) taken after down-conversion, and an unsigned phase word `theta`. It turns the feedback vector by `theta` and subtracts the turned vector from the baseband pair. The resulting return pair drives the forward path, so that the loop cancels the amplifier's distortion.

The rotation coefficients come from one stored table. That table holds the first quarter of a cosine wave, end points included. The other three quadrants are reached by mirroring the table address and negating the value read. The sine coefficient is the cosine of the phase less a quarter turn, which is a second read of the same table at an offset address. The loop's stability depends on a short delay, so the path has a fixed depth of three registers: coefficient fetch, multiply, and subtract. It takes one new sample every cycle.

Top module: `fbrot_loop_rotsub`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly three clock edges, and the return pair for a sample appears on the same edge as its valid flag.
- R2: While `rst_n` is low, `out_valid`, `ret_i` and `ret_q` are all zero.
- R3: With S = 2^(CW-2) and F = CW-2, the rotated pair is rI = sat((C*fb_i - Sn*fb_q + 2^(F-1)) >> F) and rQ = sat((Sn*fb_i + C*fb_q + 2^(F-1)) >> F). Here >> is an arithmetic (floor) shift and sat clamps to the DW-bit signed range.
- R4: The cosine coefficient C for phase word t (2^PW codes per full turn) has magnitude floor(|cos(2*pi*t/2^PW)|*S + 0.5) and takes the sign of the cosine. At t = 0 this gives C = S and Sn = 0, so the feedback passes through unchanged.
- R5: The sine coefficient Sn equals the cosine coefficient for phase word (t - 2^(PW-2)) mod 2^PW. At t = 2^(PW-2) this gives rI = sat(-fb_q) and rQ = fb_i.
- R6: ret_i = sat(in_i - rI) and ret_q = sat(in_q - rQ). They clamp at the most positive and most negative codes and never wrap.
- R7: Rotated values that exceed the DW-bit range, such as a full-scale feedback turned by an eighth of a turn, are clamped before the subtraction.
- R8: A new sample is accepted on every clock edge with no idle cycles. Back-to-back samples with different phases each produce their own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a live sample on the inputs this cycle |
| in_i | input | DW | Baseband in-phase sample, signed |
| in_q | input | DW | Baseband quadrature sample, signed |
| fb_i | input | DW | Feedback in-phase sample, signed |
| fb_q | input | DW | Feedback quadrature sample, signed |
| theta | input | PW | Correction phase, unsigned, full turn = 2^PW |
| out_valid | output | 1 | Marks a live return pair |
| ret_i | output | DW | In-phase return sample, signed |
| ret_q | output | DW | Quadrature return sample, signed |

## Verification
The bench drives phases at the four quadrant boundaries. At those phases a wrong mirror address or a missing negation shows up as a feedback vector that is turned the wrong way or flipped in sign. It also drives full-scale and most-negative feedback and input codes at odd multiples of an eighth turn, where a design that wraps instead of clamping returns a value of the opposite sign. The valid flag is toggled at random while data streams every cycle, so a pipeline stage that stalls or drops a sample is caught. The phase word is also stepped through its wrap-around point, which catches a sine offset that is off by one quadrant.

// File: rtl/fbrot_pkg.sv
package fbrot_pkg;

    typedef enum logic [1:0] {
        QD_FIRST  = 2'd0,
        QD_SECOND = 2'd1,
        QD_THIRD  = 2'd2,
        QD_FOURTH = 2'd3
    } quad_e;

    // Quarter-wave cosine magnitude at index idx of qsize steps, scaled and rounded half up.
    function automatic int qcos_entry(int idx, int qsize, int scale);
        real ang;
        ang = 1.5707963267948966 * real'(idx) / real'(qsize);
        return int'($floor($cos(ang) * real'(scale) + 0.5));
    endfunction

endpackage

// File: rtl/fbrot_coef_rom.sv
module fbrot_coef_rom #(
    parameter int PW = 10,
    parameter int CW = 12
) (
    input  logic [PW-1:0]        phase,
    output logic signed [CW-1:0] coef
);
    import fbrot_pkg::*;

    localparam int QW    = PW - 2;
    localparam int QN    = 1 << QW;
    localparam int SCALE = 1 << (CW - 2);

    logic signed [CW-1:0] tbl [0:QN];

    for (genvar k = 0; k <= QN; k++) begin : g_tbl
        localparam int V = qcos_entry(k, QN, SCALE);
        assign tbl[k] = CW'(V);
    end

    quad_e         quad;
    logic [QW:0]   addr_fwd;
    logic [QW:0]   addr_mir;

    always_comb begin
        quad     = quad_e'(phase[PW-1:PW-2]);
        addr_fwd = {1'b0, phase[QW-1:0]};
        addr_mir = (QW+1)'(QN) - addr_fwd;
        case (quad)
            QD_FIRST:  coef =  tbl[addr_fwd];
            QD_SECOND: coef = -tbl[addr_mir];
            QD_THIRD:  coef = -tbl[addr_fwd];
            default:   coef =  tbl[addr_mir];
        endcase
    end

endmodule

// File: rtl/fbrot_cmul.sv
module fbrot_cmul #(
    parameter int DW = 12,
    parameter int CW = 12
) (
    input  logic signed [CW-1:0] c_cos,
    input  logic signed [CW-1:0] c_sin,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] x_q,
    output logic signed [DW-1:0] r_i,
    output logic signed [DW-1:0] r_q
);
    localparam int MW = DW + CW;
    localparam int AW = MW + 2;
    localparam int F  = CW - 2;
    localparam logic signed [AW-1:0] HALF = AW'(1) <<< (F - 1);
    localparam logic signed [AW-1:0] HI   = (AW'(1) <<< (DW - 1)) - AW'(1);
    localparam logic signed [AW-1:0] LO   = -(AW'(1) <<< (DW - 1));

    logic signed [MW-1:0] p_ci, p_sq, p_si, p_cq;
    logic signed [AW-1:0] acc_i, acc_q, sh_i, sh_q;

    always_comb begin
        p_ci  = c_cos * x_i;
        p_sq  = c_sin * x_q;
        p_si  = c_sin * x_i;
        p_cq  = c_cos * x_q;
        acc_i = AW'(p_ci) - AW'(p_sq) + HALF;
        acc_q = AW'(p_si) + AW'(p_cq) + HALF;
        sh_i  = acc_i >>> F;
        sh_q  = acc_q >>> F;
        if (sh_i > HI)      r_i = DW'(HI);
        else if (sh_i < LO) r_i = DW'(LO);
        else                r_i = DW'(sh_i);
        if (sh_q > HI)      r_q = DW'(HI);
        else if (sh_q < LO) r_q = DW'(LO);
        else                r_q = DW'(sh_q);
    end

endmodule

// File: rtl/fbrot_satsub.sv
module fbrot_satsub #(
    parameter int DW = 12
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] y
);
    localparam logic signed [DW-1:0] HI = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] LO = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0] ax, nbx, sum;

    always_comb begin
        ax  = {a[DW-1], a};
        nbx = ~{b[DW-1], b};
        sum = ax + nbx + (DW+1)'(1);
        if (sum[DW] != sum[DW-1]) y = sum[DW] ? LO : HI;
        else                      y = sum[DW-1:0];
    end

endmodule

// File: rtl/fbrot_loop_rotsub.sv
module fbrot_loop_rotsub #(
    parameter int DW = 12,
    parameter int CW = 12,
    parameter int PW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic signed [DW-1:0] fb_i,
    input  logic signed [DW-1:0] fb_q,
    input  logic [PW-1:0]        theta,
    output logic                 out_valid,
    output logic signed [DW-1:0] ret_i,
    output logic signed [DW-1:0] ret_q
);
    localparam int QN = 1 << (PW - 2);

    typedef struct packed {
        logic                 s1_v;
        logic signed [CW-1:0] s1_cos;
        logic signed [CW-1:0] s1_sin;
        logic signed [DW-1:0] s1_i;
        logic signed [DW-1:0] s1_q;
        logic signed [DW-1:0] s1_fi;
        logic signed [DW-1:0] s1_fq;
        logic                 s2_v;
        logic signed [DW-1:0] s2_i;
        logic signed [DW-1:0] s2_q;
        logic signed [DW-1:0] s2_ri;
        logic signed [DW-1:0] s2_rq;
        logic                 s3_v;
        logic signed [DW-1:0] s3_i;
        logic signed [DW-1:0] s3_q;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [PW-1:0]        phase_sel [2];
    logic signed [CW-1:0] coef_rd   [2];
    logic signed [DW-1:0] rot_i, rot_q, sub_i, sub_q;

    assign phase_sel[0] = theta;
    assign phase_sel[1] = theta - PW'(QN);

    for (genvar p = 0; p < 2; p++) begin : g_port
        fbrot_coef_rom #(.PW(PW), .CW(CW)) u_rom (
            .phase (phase_sel[p]),
            .coef  (coef_rd[p])
        );
    end

    fbrot_cmul #(.DW(DW), .CW(CW)) u_cmul (
        .c_cos (pipe_q.s1_cos),
        .c_sin (pipe_q.s1_sin),
        .x_i   (pipe_q.s1_fi),
        .x_q   (pipe_q.s1_fq),
        .r_i   (rot_i),
        .r_q   (rot_q)
    );

    fbrot_satsub #(.DW(DW)) u_sub_i (.a(pipe_q.s2_i), .b(pipe_q.s2_ri), .y(sub_i));
    fbrot_satsub #(.DW(DW)) u_sub_q (.a(pipe_q.s2_q), .b(pipe_q.s2_rq), .y(sub_q));

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.s1_v   = in_valid;
        pipe_d.s1_cos = coef_rd[0];
        pipe_d.s1_sin = coef_rd[1];
        pipe_d.s1_i   = in_i;
        pipe_d.s1_q   = in_q;
        pipe_d.s1_fi  = fb_i;
        pipe_d.s1_fq  = fb_q;
        pipe_d.s2_v   = pipe_q.s1_v;
        pipe_d.s2_i   = pipe_q.s1_i;
        pipe_d.s2_q   = pipe_q.s1_q;
        pipe_d.s2_ri  = rot_i;
        pipe_d.s2_rq  = rot_q;
        pipe_d.s3_v   = pipe_q.s2_v;
        pipe_d.s3_i   = sub_i;
        pipe_d.s3_q   = sub_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s3_v;
    assign ret_i     = pipe_q.s3_i;
    assign ret_q     = pipe_q.s3_q;

endmodule

// File: rtl/fbrot_chk.sv
module fbrot_chk #(
    parameter int DW = 12,
    parameter int CW = 12,
    parameter int PW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic signed [DW-1:0] fb_i,
    input  logic signed [DW-1:0] fb_q,
    input  logic [PW-1:0]        theta,
    input  logic                 out_valid,
    input  logic signed [DW-1:0] ret_i,
    input  logic signed [DW-1:0] ret_q
);
    localparam int QN = 1 << (PW - 2);

    function automatic logic signed [DW-1:0] clampv(int v);
        int hi, lo;
        hi = (1 << (DW - 1)) - 1;
        lo = -(1 << (DW - 1));
        if (v > hi) return DW'(hi);
        if (v < lo) return DW'(lo);
        return DW'(v);
    endfunction

    logic [1:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_cnt <= '0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = (warm_cnt == 2'd3);

    // R2: outputs held at zero in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r2: assert (out_valid == 1'b0 && ret_i == '0 && ret_q == '0);
        end
    end

    // R1: valid follows the input flag three edges later
    p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 3)));

    // R4: zero phase passes feedback straight to the subtractor
    p_zero_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 3) && $past(theta, 3) == '0) |->
        (ret_i == clampv(int'($past(in_i, 3)) - int'($past(fb_i, 3))) &&
         ret_q == clampv(int'($past(in_q, 3)) - int'($past(fb_q, 3)))));

    // R5: quarter-turn phase swaps the feedback axes
    p_quarter_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 3) && $past(theta, 3) == PW'(QN)) |->
        (ret_i == clampv(int'($past(in_i, 3)) - int'(clampv(-int'($past(fb_q, 3))))) &&
         ret_q == clampv(int'($past(in_q, 3)) - int'($past(fb_i, 3)))));

endmodule

bind fbrot_loop_rotsub fbrot_chk #(.DW(DW), .CW(CW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .fb_i      (fb_i),
    .fb_q      (fb_q),
    .theta     (theta),
    .out_valid (out_valid),
    .ret_i     (ret_i),
    .ret_q     (ret_q)
);

// File: tb/fbrot_loop_rotsub_tb.sv
module fbrot_loop_rotsub_tb_top;
    localparam int DW = 12;
    localparam int CW = 12;
    localparam int PW = 10;
    localparam int NPH = 1 << PW;
    localparam int QN  = NPH / 4;
    localparam int S   = 1 << (CW - 2);
    localparam int F   = CW - 2;
    localparam int HI  = (1 << (DW - 1)) - 1;
    localparam int LO  = -(1 << (DW - 1));

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_i = '0, in_q = '0, fb_i = '0, fb_q = '0;
    logic [PW-1:0]        theta = '0;
    logic                 out_valid;
    logic signed [DW-1:0] ret_i, ret_q;

    always #10 clk = ~clk;

    fbrot_loop_rotsub #(.DW(DW), .CW(CW), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .fb_i(fb_i), .fb_q(fb_q), .theta(theta),
        .out_valid(out_valid), .ret_i(ret_i), .ret_q(ret_q)
    );

    typedef struct packed {
        logic        v;
        logic [31:0] ei;
        logic [31:0] eq;
        logic [31:0] tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    logic [31:0] cur_tag = "R3";

    function automatic int satw(longint v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return int'(v);
    endfunction

    function automatic int coef(int t);
        real ang, cv, mag;
        ang = 6.283185307179586 * real'(t % NPH) / real'(NPH);
        cv  = $cos(ang);
        mag = (cv < 0.0) ? -cv : cv;
        return (cv < 0.0) ? -int'($floor(mag * real'(S) + 0.5))
                          :  int'($floor(mag * real'(S) + 0.5));
    endfunction

    function automatic exp_t model(logic v, int ii, int iq, int fi, int fq, int t);
        exp_t   e;
        int     c, s, ri, rq;
        longint ai, aq;
        c  = coef(t);
        s  = coef((t - QN + NPH) % NPH);
        ai = longint'(c) * fi - longint'(s) * fq + (longint'(1) << (F - 1));
        aq = longint'(s) * fi + longint'(c) * fq + (longint'(1) << (F - 1));
        ri = satw(ai >>> F);
        rq = satw(aq >>> F);
        e.v   = v;
        e.ei  = satw(longint'(ii) - ri);
        e.eq  = satw(longint'(iq) - rq);
        e.tag = cur_tag;
        return e;
    endfunction

    task automatic check_one(string req, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // compare the oldest prediction, then drive and predict a new sample
    task automatic step(logic v, int ii, int iq, int fi, int fq, int t);
        exp_t e;
        @(negedge clk);
        cyc++;
        if (exp_q.size() == 3) begin
            e = exp_q.pop_front();
            check_one("R1", int'(out_valid), int'(e.v));
            if (e.v) begin
                check_one({"", string'(e.tag)}, int'(ret_i), int'(signed'(e.ei)));
                check_one({"", string'(e.tag)}, int'(ret_q), int'(signed'(e.eq)));
            end
        end
        in_valid = v;
        in_i = DW'(ii); in_q = DW'(iq); fb_i = DW'(fi); fb_q = DW'(fq);
        theta = PW'(t);
        exp_q.push_back(model(v, ii, iq, fi, fq, t));
    endtask

    function automatic int rnd_s();
        return int'($urandom_range(0, (1 << DW) - 1)) + LO;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        exp_t blank;
        blank = '0;
        // R2: reset state
        repeat (3) @(negedge clk);
        check_one("R2", int'(out_valid), 0);
        check_one("R2", int'(ret_i), 0);
        check_one("R2", int'(ret_q), 0);
        for (int k = 0; k < 3; k++) exp_q.push_back(blank);
        rst_n = 1'b1;

        // R4: zero phase
        cur_tag = "R4";
        for (int k = 0; k < 20; k++) step(1'b1, rnd_s(), rnd_s(), rnd_s(), rnd_s(), 0);

        // R5: quadrant boundaries and phases next to them
        cur_tag = "R5";
        for (int k = 0; k < 40; k++) begin
            int t;
            t = ((k % 4) * QN + ((k / 4) % 3) - 1 + NPH) % NPH;
            step(1'b1, rnd_s(), rnd_s(), rnd_s(), rnd_s(), t);
        end

        // R7: full-scale feedback at odd eighth turns
        cur_tag = "R7";
        for (int k = 0; k < 16; k++) begin
            int t;
            t = (2 * (k % 4) + 1) * (NPH / 8);
            step(1'b1, 0, 0, (k & 4) ? LO : HI, (k & 8) ? LO : HI, t);
        end

        // R6: extreme inputs against extreme feedback
        cur_tag = "R6";
        for (int k = 0; k < 24; k++) begin
            step(1'b1, (k & 1) ? HI : LO, (k & 2) ? HI : LO,
                 (k & 1) ? LO : HI, (k & 2) ? LO : HI, (k * 37) % NPH);
        end

        // R8: back-to-back samples with toggling valid and sweeping phase
        cur_tag = "R8";
        for (int k = 0; k < 300; k++)
            step(1'($urandom_range(0, 1)), rnd_s(), rnd_s(), rnd_s(), rnd_s(),
                 (k * 7 + NPH - 20) % NPH);

        // R3: random rotation, mid-range values
        cur_tag = "R3";
        for (int k = 0; k < 400; k++)
            step(1'b1, rnd_s() / 2, rnd_s() / 2, rnd_s(), rnd_s(),
                 int'($urandom_range(0, NPH - 1)));

        // drain
        for (int k = 0; k < 3; k++) step(1'b0, 0, 0, 0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule